// File: doc/BRIEF.md
# Maximal-Length Pseudo-Random Bit Generator

This block produces a pseudo-random bit stream from an n-stage linear feedback shift register. Its feedback polynomial is a parameter, written as a tap mask and taken from a primitive polynomial. Every addition in the feedback path is modulo 2, which is an XOR with no carry. With a primitive polynomial the state runs through every nonzero n-bit value exactly once and then repeats.

Two static inputs shape the generator at run time. The first picks the feedback topology. In external mode a single XOR tree gathers the tapped stages and drives the low end of the register. In internal mode the top bit is sent back into XOR gates that sit between the stages. The second input swaps the polynomial for its reciprocal, which is also primitive. One instance therefore covers four distinct sequences for each width.

The all-zero state would lock the register. Reset loads a nonzero seed and never clears the register, and a request to load an all-zero seed loads 1 in its place. The serial output is the top stage, and the whole state is brought out in parallel.

Top module: `lfsr_mseq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `state_o` to the parameter `RST_SEED`. A zero `RST_SEED` is replaced by 1. The default value is 1.
- R2: When `load` is high and `rst` is low, the next state is `seed`, whatever the value of `en`.
- R3: When `load` is high and `seed` is all zero, the next state is 1 (only bit 0 set) and not zero.
- R4: When `rst`, `load` and `en` are all low, the state holds its value.
- R5: External mode (`topo_int` = 0): each enabled step gives next = {s[n-2:0], f}. Here f is the XOR of every stage s[k-1] whose mask bit k-1 is set.
- R6: Internal mode (`topo_int` = 1): each enabled step gives next[0] = s[n-1]. For 1 <= i <= n-1 it gives next[i] = s[i-1] XOR (mask[i-1] AND s[n-1]).
- R7: With `recip` = 1 the effective mask is the reciprocal polynomial. Its bit k-1 equals bit n-k-1 of `POLY` for 1 <= k <= n-1, and its bit n-1 is 1.
- R8: With a primitive polynomial, from any nonzero seed, in either topology and with either polynomial of the pair, the state returns to the seed after exactly 2^n - 1 steps. Along the way it never reaches zero and never repeats a state.
- R9: `bit_o` always equals the top stage, `state_o[n-1]`.
- R10: Mask bit k-1 holds the coefficient of x^k. Bit n-1 (for x^n) is always forced to 1. The default is n = 8 with mask 8'h8E, which is 1 + x^2 + x^3 + x^4 + x^8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, loads the nonzero reset seed |
| en | input | 1 | Advance one step per clock while high |
| load | input | 1 | Load `seed` on the next edge; takes priority over `en` |
| seed | input | WIDTH | Seed value; zero is replaced by 1 |
| topo_int | input | 1 | 0 selects external feedback, 1 selects internal feedback |
| recip | input | 1 | 1 selects the reciprocal of `POLY` |
| bit_o | output | 1 | Serial pseudo-random bit (top stage) |
| state_o | output | WIDTH | Parallel register state |

## Verification
The hardest property to reach from the ports is the full cycle. It only shows after all 2^n - 1 states have gone by, and a wrong tap can still give a shorter loop that looks random. The bench loads a seed and runs the generator freely until the seed comes back. On every step it compares the state with an independent model. It also marks each visited state in a table, so that repeats and zeros are caught. This is done for both topologies, both polynomials of each pair, at widths 3 and 8, and from a second seed. Short hand-computed single steps from state 0x80 pin down the exact tap positions that a full-cycle check alone would not catch.

// File: rtl/lfsr_mseq_pkg.sv
package lfsr_mseq_pkg;

    typedef enum logic {
        FB_EXTERNAL = 1'b0,
        FB_INTERNAL = 1'b1
    } fb_topo_e;

endpackage

// File: rtl/lfsr_mseq_taps.sv
// Effective tap mask: the parameter polynomial or its reciprocal.
module lfsr_mseq_taps #(
    parameter int W = 8
) (
    input  logic [W-1:0] poly,
    input  logic         use_recip,
    output logic [W-1:0] mask
);
    logic [W-1:0] rev_mask;

    // x^k maps to x^(n-k); the constant term becomes x^n.
    assign rev_mask[W-1] = 1'b1;
    for (genvar k = 1; k < W; k++) begin : g_rev
        assign rev_mask[k-1] = poly[W-k-1];
    end

    assign mask = use_recip ? rev_mask : poly;
endmodule

// File: rtl/lfsr_mseq_ext.sv
// External feedback: one XOR tree drives stage 0.
module lfsr_mseq_ext #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] mask,
    output logic [W-1:0] nxt
);
    logic fb;

    assign fb  = ^(cur & mask);
    assign nxt = {cur[W-2:0], fb};
endmodule

// File: rtl/lfsr_mseq_int.sv
// Internal feedback: the top stage is folded into each tapped link.
module lfsr_mseq_int #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] mask,
    output logic [W-1:0] nxt
);
    logic top;

    assign top    = cur[W-1];
    assign nxt[0] = top;
    for (genvar i = 1; i < W; i++) begin : g_link
        assign nxt[i] = cur[i-1] ^ (mask[i-1] & top);
    end
endmodule

// File: rtl/lfsr_mseq.sv
module lfsr_mseq
    import lfsr_mseq_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] POLY     = 8'h8E,
    parameter logic [WIDTH-1:0] RST_SEED = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    input  logic             topo_int,
    input  logic             recip,
    output logic             bit_o,
    output logic [WIDTH-1:0] state_o
);
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] TOP_BIT  = ONE << (WIDTH-1);
    localparam logic [WIDTH-1:0] POLY_FIX = POLY | TOP_BIT;
    localparam logic [WIDTH-1:0] SEED_FIX = (RST_SEED == '0) ? ONE : RST_SEED;

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } gen_t;

    gen_t             gen_d, gen_q;
    fb_topo_e         topo;
    logic [WIDTH-1:0] tap_mask;
    logic [WIDTH-1:0] ext_nxt;
    logic [WIDTH-1:0] int_nxt;

    assign topo = fb_topo_e'(topo_int);

    lfsr_mseq_taps #(.W(WIDTH)) u_taps (
        .poly      (POLY_FIX),
        .use_recip (recip),
        .mask      (tap_mask)
    );

    lfsr_mseq_ext #(.W(WIDTH)) u_ext (
        .cur  (gen_q.sr),
        .mask (tap_mask),
        .nxt  (ext_nxt)
    );

    lfsr_mseq_int #(.W(WIDTH)) u_int (
        .cur  (gen_q.sr),
        .mask (tap_mask),
        .nxt  (int_nxt)
    );

    always_comb begin
        gen_d = gen_q;
        if (rst) begin
            gen_d.sr = SEED_FIX;
        end else if (load) begin
            gen_d.sr = (seed == '0) ? ONE : seed;
        end else if (en) begin
            gen_d.sr = (topo == FB_INTERNAL) ? int_nxt : ext_nxt;
        end
    end

    always_ff @(posedge clk) begin
        gen_q <= gen_d;
    end

    assign state_o = gen_q.sr;
    assign bit_o   = gen_q.sr[WIDTH-1];
endmodule

// File: rtl/lfsr_mseq_chk.sv
module lfsr_mseq_chk #(
    parameter int           W    = 8,
    parameter logic [W-1:0] SEED = 1
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         load,
    input logic [W-1:0] seed,
    input logic         bit_o,
    input logic [W-1:0] state_o
);
    logic rst_q    = 1'b0;
    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) rst_seen <= 1'b1;
    end

    assert_reset_seed_R1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> state_o == SEED);

    assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (load && seed != '0) |=> state_o == $past(seed));

    assert_zero_seed_R3: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> state_o == W'(1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_seen && !load && !en) |=> $stable(state_o));

    assert_never_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rst_seen |-> state_o != '0);

    assert_serial_top_R9: assert property (@(posedge clk) disable iff (rst)
        rst_seen |-> bit_o == state_o[W-1]);
endmodule

bind lfsr_mseq lfsr_mseq_chk #(.W(WIDTH), .SEED(SEED_FIX)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .load    (load),
    .seed    (seed),
    .bit_o   (bit_o),
    .state_o (state_o)
);

// File: tb/lfsr_mseq_bench.sv
module lfsr_mseq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic       topo_int = 1'b0;
    logic       recip = 1'b0;
    logic [7:0] seed8 = '0;
    logic [2:0] seed3 = '0;
    logic       bit8, bit3;
    logic [7:0] st8;
    logic [2:0] st3;
    int         n_run = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    lfsr_mseq u_lfsr_mseq (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed8),
        .topo_int(topo_int), .recip(recip), .bit_o(bit8), .state_o(st8)
    );

    lfsr_mseq #(.WIDTH(3), .POLY(3'b110), .RST_SEED(3'd1)) u_lfsr_mseq_n3 (
        .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed3),
        .topo_int(topo_int), .recip(recip), .bit_o(bit3), .state_o(st3)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Bench model built from R5, R6, R7, R10.
    function automatic logic [7:0] eff_mask(logic [7:0] p, bit rc, int w);
        logic [7:0] r;
        p[w-1] = 1'b1;
        if (!rc) return p;
        r = '0;
        r[w-1] = 1'b1;
        for (int k = 1; k < w; k++) r[k-1] = p[w-k-1];
        return r;
    endfunction

    function automatic logic [7:0] model_next(logic [7:0] s, logic [7:0] m, bit intl, int w);
        logic [7:0] wm;
        logic [7:0] n;
        logic       msb;
        wm  = 8'((9'd1 << w) - 1);
        msb = s[w-1];
        n   = '0;
        if (!intl) begin
            n = ((s << 1) | {7'd0, ^(s & m & wm)}) & wm;
        end else begin
            n[0] = msb;
            for (int i = 1; i < w; i++) n[i] = s[i-1] ^ (m[i-1] & msb);
        end
        return n;
    endfunction

    function automatic logic [7:0] cur_state(int w);
        return (w == 8) ? st8 : {5'd0, st3};
    endfunction

    task automatic t_reset();
        rst = 1'b1; en = 1'b1; load = 1'b0;
        tick(); tick();
        rst = 1'b0; en = 1'b0;
        chk(st8 == 8'h01, "R1 reset seed n8", st8, 8'h01);
        chk(st3 == 3'd1, "R1 reset seed n3", st3, 1);
        chk(bit8 == st8[7], "R9 serial bit n8", bit8, st8[7]);
    endtask

    task automatic load_step(input logic [7:0] sd, output logic [7:0] res);
        load = 1'b1; seed8 = sd; seed3 = sd[2:0];
        tick();
        load = 1'b0; en = 1'b1;
        tick();
        en = 1'b0;
        res = st8;
    endtask

    task automatic t_hold();
        logic [7:0] r;
        load_step(8'h5A, r);
        tick(); tick(); tick();
        chk(st8 == r, "R4 hold with en low", st8, r);
        chk(bit8 == r[7], "R9 serial bit after hold", bit8, r[7]);
    endtask

    task automatic t_load_prio();
        load = 1'b1; en = 1'b1; seed8 = 8'h3C; seed3 = 3'd5;
        tick();
        load = 1'b0; en = 1'b0;
        chk(st8 == 8'h3C, "R2 load over enable", st8, 8'h3C);
        chk(st3 == 3'd5, "R2 load over enable n3", st3, 5);
    endtask

    task automatic t_zero_seed();
        load = 1'b1; seed8 = 8'h00; seed3 = 3'd0;
        tick();
        load = 1'b0;
        chk(st8 == 8'h01, "R3 zero seed replaced", st8, 8'h01);
        chk(st3 == 3'd1, "R3 zero seed replaced n3", st3, 1);
    endtask

    task automatic t_hand();
        logic [7:0] r;
        topo_int = 1'b0; recip = 1'b0;
        load_step(8'h80, r);
        chk(r == 8'h01, "R5 R10 external step from 80", r, 8'h01);
        topo_int = 1'b1;
        load_step(8'h80, r);
        chk(r == 8'h1D, "R6 R10 internal step from 80", r, 8'h1D);
        recip = 1'b1;
        load_step(8'h80, r);
        chk(r == 8'h71, "R7 reciprocal internal step from 80", r, 8'h71);
        topo_int = 1'b0;
        load_step(8'hB8, r);
        chk(r == 8'h70, "R7 reciprocal external step from B8", r, 8'h70);
        recip = 1'b0;
    endtask

    task automatic t_period(input bit intl, input bit rc, input int w, input logic [7:0] sd);
        bit         seen [0:255];
        logic [7:0] start, exp_s, c, m;
        int         steps, mism, bad;
        string      tag;
        m = eff_mask((w == 8) ? 8'h8E : 8'h06, rc, w);
        topo_int = intl; recip = rc;
        load = 1'b1; seed8 = sd; seed3 = sd[2:0];
        tick();
        load = 1'b0; en = 1'b1;
        start = cur_state(w);
        exp_s = start;
        seen[start] = 1'b1;
        steps = 0; mism = 0; bad = 0;
        for (int i = 0; i < 300; i++) begin
            tick();
            c = cur_state(w);
            exp_s = model_next(exp_s, m, intl, w);
            if (c != exp_s) mism++;
            steps++;
            if (c == start) break;
            if (c == 8'h00 || seen[c]) bad++;
            seen[c] = 1'b1;
        end
        en = 1'b0;
        tag = $sformatf("%s%s n%0d", intl ? "R6" : "R5", rc ? " R7" : "", w);
        chk(mism == 0, {tag, " sequence matches model"}, mism, 0);
        chk(steps == (1 << w) - 1, $sformatf("R8 period n%0d int%0d rc%0d", w, intl, rc),
            steps, (1 << w) - 1);
        chk(bad == 0, $sformatf("R8 no zero or repeat n%0d int%0d rc%0d", w, intl, rc), bad, 0);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_hold();
        t_load_prio();
        t_zero_seed();
        t_hand();
        for (int t = 0; t < 2; t++) begin
            for (int r = 0; r < 2; r++) begin
                t_period(t[0], r[0], 8, 8'h01);
                t_period(t[0], r[0], 3, 8'h01);
            end
        end
        t_period(1'b0, 1'b0, 8, 8'hA5);
        t_period(1'b1, 1'b1, 3, 8'h06);
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule